// File: doc/BRIEF.md
# Bit Count and Reversal Unit

This block is a single-operand datapath slice for a 32-bit processor core. From one source word it produces one of five results: the count of leading zero bits, the word with its four bytes in reverse order, the word with the two bytes of each 16-bit half exchanged, the low halfword byte-exchanged and sign-extended to the full width, or the word with its bit order mirrored. A 3-bit code picks the operation. A code outside the five defined ones hands the source back unchanged.

The unit has one stage. A source presented with `in_valid` high is turned into a result. That result appears on `out_result` at the next rising clock edge, with `out_valid` high. When `in_valid` is low the result register keeps its contents. The width is a parameter and must be a multiple of 16. The default of 32 matches the processor word. Flags and every other arithmetic operation belong to neighbouring units.

Top module: `bitrev_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `out_valid` = 0 and `out_result` = 0.
- R2: `out_valid` equals the value `in_valid` had at the previous rising edge (one cycle of latency). The result of a valid input appears on `out_result` in that same cycle.
- R3: Op code 0 (leading-zero count) returns the number of zero bits above the highest set bit of `in_src`. It returns 32 for an all-zero source and 0 when bit 31 is set.
- R4: Op code 1 (word byte reverse) places source byte k (bits 8k+7..8k) at result byte 3-k.
- R5: Op code 2 (halfword byte swap) exchanges bits 7..0 with bits 15..8, and bits 23..16 with bits 31..24, each pair on its own.
- R6: Op code 3 (signed halfword swap) sets result bits 15..8 to source bits 7..0 and result bits 7..0 to source bits 15..8. It fills result bits 31..16 with copies of source bit 7.
- R7: Op code 4 (bit reverse) sets result bit i to source bit 31-i for every i.
- R8: Op codes 5, 6 and 7 return `in_src` unchanged.
- R9: A cycle with `in_valid` low leaves `out_result` unchanged and drives `out_valid` low, whatever `in_op` and `in_src` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Source and op code are valid this cycle |
| in_op | input | 3 | Operation code: 0 leading zeros, 1 word byte reverse, 2 halfword swap, 3 signed halfword swap, 4 bit reverse, 5..7 pass through |
| in_src | input | 32 | Source operand |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | 32 | Registered result |

## Verification
The leading-zero count is tried on an all-zero word, on a word with only the top bit set, on a word with only bit 0 set, on an all-ones-below-the-top word and on a word with a mid-range leading bit. Together these show whether the count is off by one, saturates and is anchored at the correct end. The permutation modes use sources whose bytes are all distinct, such as 0x12345678 and 0xA1B2C3D4, so a wrong byte lane or a swap across halves shows in the result. The signed swap is fed sources whose source bit 7 is clear in one case and set in another, with contradicting bit 15 and upper-half contents, to tell the correct sign bit from a wrong one. Undefined codes, idle cycles carrying other data, and a reset in the middle of a stream show that nothing leaks through.

// File: rtl/bitrev_pkg.sv
package bitrev_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_CLZ     = 3'd0,
    OP_BREV    = 3'd1,
    OP_HSWAP   = 3'd2,
    OP_HSWAPSX = 3'd3,
    OP_BITREV  = 3'd4
  } op_e;
endpackage

// File: rtl/bitrev_lzc.sv
module bitrev_lzc #(
  parameter int W     = 32,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     src,
  output logic [CNT_W-1:0] count
);
  logic found;

  always_comb begin
    count = CNT_W'(W);
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && src[i]) begin
        count = CNT_W'(W - 1 - i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bitrev_bytes.sv
module bitrev_bytes #(
  parameter int W = 32
) (
  input  logic [W-1:0] src,
  output logic [W-1:0] word_rev,
  output logic [W-1:0] half_swap,
  output logic [W-1:0] half_swap_sx
);
  localparam int BW = 8;
  localparam int NB = W / BW;
  localparam int NH = W / (2 * BW);

  for (genvar b = 0; b < NB; b++) begin : g_word
    assign word_rev[b*BW +: BW] = src[(NB-1-b)*BW +: BW];
  end

  for (genvar h = 0; h < NH; h++) begin : g_half
    assign half_swap[h*2*BW      +: BW] = src[h*2*BW + BW +: BW];
    assign half_swap[h*2*BW + BW +: BW] = src[h*2*BW      +: BW];
  end

  assign half_swap_sx = {{(W - 2*BW){src[BW-1]}}, src[BW-1:0], src[2*BW-1:BW]};
endmodule

// File: rtl/bitrev_mirror.sv
module bitrev_mirror #(
  parameter int W = 32
) (
  input  logic [W-1:0] src,
  output logic [W-1:0] mirrored
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign mirrored[i] = src[W-1-i];
  end
endmodule

// File: rtl/bitrev_unit.sv
module bitrev_unit
  import bitrev_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   in_op,
  input  logic [DATA_W-1:0] in_src,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [CNT_W-1:0]  lz_count;
  logic [DATA_W-1:0] word_rev;
  logic [DATA_W-1:0] half_swap;
  logic [DATA_W-1:0] half_swap_sx;
  logic [DATA_W-1:0] mirrored;
  logic [DATA_W-1:0] next_result;

  bitrev_lzc #(.W(DATA_W), .CNT_W(CNT_W)) u_lzc (
    .src   (in_src),
    .count (lz_count)
  );

  bitrev_bytes #(.W(DATA_W)) u_bytes (
    .src          (in_src),
    .word_rev     (word_rev),
    .half_swap    (half_swap),
    .half_swap_sx (half_swap_sx)
  );

  bitrev_mirror #(.W(DATA_W)) u_mirror (
    .src      (in_src),
    .mirrored (mirrored)
  );

  always_comb begin
    case (in_op)
      OP_CLZ:     next_result = {{(DATA_W - CNT_W){1'b0}}, lz_count};
      OP_BREV:    next_result = word_rev;
      OP_HSWAP:   next_result = half_swap;
      OP_HSWAPSX: next_result = half_swap_sx;
      OP_BITREV:  next_result = mirrored;
      default:    next_result = in_src;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= next_result;
      end
    end
  end
endmodule

// File: rtl/bitrev_unit_chk.sv
module bitrev_unit_chk
  import bitrev_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [OP_W-1:0]   in_op,
  input logic [DATA_W-1:0] in_src,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && out_result == '0));

  // R2
  a_r2_valid_delay: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R3
  a_r3_clz_empty: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_CLZ && in_src == '0) |=> out_result == DATA_W'(DATA_W));

  // R3
  a_r3_clz_top: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_CLZ && in_src[DATA_W-1]) |=> out_result == '0);

  // R4
  a_r4_brev_ends: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_BREV) |=>
      (out_result[7:0] == $past(in_src[DATA_W-1 -: 8]) &&
       out_result[DATA_W-1 -: 8] == $past(in_src[7:0])));

  // R5
  a_r5_hswap_low: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_HSWAP) |=>
      (out_result[15:8] == $past(in_src[7:0]) && out_result[7:0] == $past(in_src[15:8])));

  // R6
  a_r6_sign_fill: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_HSWAPSX) |=>
      (out_result[DATA_W-1:16] == {(DATA_W-16){$past(in_src[7])}}));

  // R7
  a_r7_mirror_ends: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_BITREV) |=>
      (out_result[0] == $past(in_src[DATA_W-1]) && out_result[DATA_W-1] == $past(in_src[0])));

  // R8
  a_r8_passthru: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op > OP_BITREV) |=> out_result == $past(in_src));

  // R9
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_result)));
endmodule

bind bitrev_unit bitrev_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_op      (in_op),
  .in_src     (in_src),
  .out_valid  (out_valid),
  .out_result (out_result)
);

// File: tb/sim_bitrev_unit.sv
module sim_bitrev_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  in_op = '0;
  logic [31:0] in_src = '0;
  logic        out_valid;
  logic [31:0] out_result;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  bitrev_unit #(.DATA_W(32)) u0 (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_src     (in_src),
    .out_valid  (out_valid),
    .out_result (out_result)
  );

  // {op, source, expected}, requirement noted per entry
  localparam int NV = 20;
  localparam logic [66:0] VEC [NV] = '{
    {3'd0, 32'h00000000, 32'h00000020},  // R3 empty
    {3'd0, 32'h80000000, 32'h00000000},  // R3 top bit
    {3'd0, 32'h00000001, 32'h0000001F},  // R3
    {3'd0, 32'h00012345, 32'h0000000F},  // R3
    {3'd0, 32'h7FFFFFFF, 32'h00000001},  // R3
    {3'd1, 32'h12345678, 32'h78563412},  // R4
    {3'd1, 32'hA1B2C3D4, 32'hD4C3B2A1},  // R4
    {3'd2, 32'h12345678, 32'h34127856},  // R5
    {3'd2, 32'hA1B2C3D4, 32'hB2A1D4C3},  // R5
    {3'd3, 32'h12345678, 32'h00007856},  // R6 positive
    {3'd3, 32'h000000F0, 32'hFFFFF000},  // R6 negative
    {3'd3, 32'hFFFF0080, 32'hFFFF8000},  // R6
    {3'd3, 32'h0000FF7F, 32'h00007FFF},  // R6 bit 15 set, bit 7 clear
    {3'd4, 32'h00000001, 32'h80000000},  // R7
    {3'd4, 32'h12345678, 32'h1E6A2C48},  // R7
    {3'd4, 32'hF0000000, 32'h0000000F},  // R7
    {3'd5, 32'hDEADBEEF, 32'hDEADBEEF},  // R8
    {3'd6, 32'h00000000, 32'h00000000},  // R8
    {3'd7, 32'h13579BDF, 32'h13579BDF},  // R8
    {3'd0, 32'h00000100, 32'h00000017}   // R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid after reset", {31'd0, out_valid}, 32'd0);
    check("R1 result after reset", out_result, 32'd0);
    rst = 1'b0;

    // table walk, back-to-back valid inputs
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_op    = VEC[i][66:64];
      in_src   = VEC[i][63:32];
      @(posedge clk);
      #1;
      check($sformatf("R3-R8 vector %0d (R2 latency)", i), out_result, VEC[i][31:0]);
      check("R2 valid", {31'd0, out_valid}, 32'd1);
    end

    // R9: idle cycles carrying other data leave the result untouched
    @(negedge clk);
    in_valid = 1'b0;
    in_op    = 3'd1;
    in_src   = 32'hCAFEF00D;
    repeat (3) begin
      @(posedge clk);
      #1;
      check("R9 idle result", out_result, 32'h00000017);
      check("R9 idle valid", {31'd0, out_valid}, 32'd0);
    end

    // R2: valid after a bubble
    @(negedge clk);
    in_valid = 1'b1;
    in_op    = 3'd2;
    in_src   = 32'h00FF1100;
    @(posedge clk);
    #1;
    check("R2 after bubble", out_result, 32'hFF000011);
    check("R2 valid after bubble", {31'd0, out_valid}, 32'd1);

    // R1: reset in the middle of a stream wins over a valid input
    @(negedge clk);
    rst      = 1'b1;
    in_valid = 1'b1;
    in_op    = 3'd4;
    in_src   = 32'h00000001;
    @(posedge clk);
    #1;
    check("R1 mid-stream reset result", out_result, 32'd0);
    check("R1 mid-stream reset valid", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    rst      = 1'b0;
    in_valid = 1'b0;

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule